// File: doc/BRIEF.md
# Radio Core Instruction Bridge

This block sits between a host processor bus and the configuration space of a sub-GHz radio core. The host talks to it through four logical channels. It writes an instruction byte, feeds operand bytes through a data-in channel, and collects results from a data-out buffer. A status byte is captured each time an instruction is accepted. The block holds the radio's byte-wide configuration registers itself. It reports the fill levels of transmit and receive FIFOs, which are kept elsewhere and arrive as inputs.

The instruction byte carries a direction flag, a burst flag and a six-bit register address. In a burst the address steps forward after every byte. A read result is produced when a dummy operand is written, or, in the auto-read forms, when the previous result is taken. Command-strobe addresses do not touch the register file. They raise a one-cycle pulse on a dedicated output line. Word-wide host accesses are reordered so that the radio sees the most significant byte first. Operand-count mistakes, reads of an empty buffer, and writes that arrive while the previous operand is still busy each raise their own one-cycle error pulse.

Top module: `rcib_bridge`

## Requirements
- R1: When an instruction is accepted, `status` takes the value {radio_nrdy, radio_state[2:0], fill}. Here fill is rx_fill when instruction bit 7 is 1 and tx_fill when it is 0, saturated at 15. `status` does not change at any other time, and an instruction written while busy is not accepted.
- R2: An instruction with bit 7 = 0 (write) and bit 6 = 0 (single), followed by one byte-wide data-in write, stores that byte at the address in instruction bits 5:0.
- R3: An instruction with bit 7 = 1 and bit 6 = 0 (single read), followed by one byte-wide dummy data-in write, places the addressed register in `dout_byte` at the next cycle.
- R4: With bit 6 = 1 (burst), the address advances by one after each byte written or fetched, and by two after each word.
- R5: An instruction with bit 6 = 0 and address 0x30 + k (k < NSTROBE) pulses `strobe[k]` alone for exactly one cycle and leaves the registers untouched. Its status fill follows bit 7 as in R1.
- R6: With `host_instr_ar` = 1, a read instruction fetches its first byte without a dummy write. In a burst read, a host read with `host_rd_ar` = 1 or 2 (3 counts as 2) replaces the buffer with that many freshly fetched bytes. Auto-read is refused with `err_operand` outside a burst read.
- R7: Word accesses convert byte order. In a word data-in write, bits 15:8 go to the current address and bits 7:0 to the next. In a word read, `dout_word` bits 15:8 hold the byte fetched first. In a word instruction write, bits 15:8 are the instruction and bits 7:0 are its first operand.
- R8: `err_operand` pulses in four cases. The first is data-in with no open instruction. The second is a word operand to a single access or to a strobe; such an operand is ignored. The third is a new instruction while a single access still lacks its operand, in which case the new instruction is still accepted. The fourth is auto-read outside a burst read.
- R9: A host read that asks for more bytes than the buffer holds pulses `err_nodata` and leaves the buffer unchanged.
- R10: An operand-carrying write accepted at one clock edge makes the block busy for the next two edges. A data-in or instruction write during that window pulses `err_overwrite` and is ignored.
- R11: After reset, `status`, `dout_word`, `strobe` and all error pulses are zero, and all registers read as zero.
- R12: Addresses at or above NREG (0x2A by default) that are not strobes read as zero, and writes to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_instr_we | input | 1 | Instruction channel write strobe |
| host_din_we | input | 1 | Data-in channel write strobe |
| host_wide | input | 1 | Current write is a word (1) or byte (0) |
| host_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| host_instr_ar | input | 1 | Instruction write with immediate first fetch |
| host_rd | input | 1 | Host takes data from the output buffer |
| host_rd_wide | input | 1 | Host read is a word (1) or byte (0) |
| host_rd_ar | input | 2 | Bytes to auto-fetch after this read |
| radio_nrdy | input | 1 | Radio core not ready |
| radio_state | input | 3 | Radio state code |
| tx_fill | input | FILLW (7) | Transmit FIFO fill level |
| rx_fill | input | FILLW (7) | Receive FIFO fill level |
| status | output | 8 | Status captured at the last accepted instruction |
| dout_byte | output | 8 | Head of the output buffer |
| dout_word | output | 16 | Head two buffer bytes, first-fetched in bits 15:8 |
| strobe | output | NSTROBE (14) | One-cycle command strobe pulses |
| err_operand | output | 1 | Operand-count error pulse |
| err_nodata | output | 1 | Read-empty error pulse |
| err_overwrite | output | 1 | Busy overwrite error pulse |

## Verification
Bad internal state can show up at the ports in several ways. A stuck address counter shows as the wrong register in the second and later bytes of a burst readback, one cycle after the fetch. A wrong mode register shows as a missing or spurious `err_operand` pulse in the cycle after the next data-in write. A busy counter that is off by one cycle shows as an overwrite pulse that comes or goes on the third consecutive operand write. A wrong byte order shows in `dout_word` right after a word fetch. Random bursts over random addresses, each checked against a bench-side register image, expose array corruption at the first readback of the damaged address.

// File: rtl/rcib_pkg.sv
package rcib_pkg;
  localparam int AW = 6;
  localparam logic [AW-1:0] STB_BASE = 6'h30;

  typedef enum logic [2:0] {
    M_IDLE = 3'd0,
    M_SWR  = 3'd1,
    M_SRD  = 3'd2,
    M_BWR  = 3'd3,
    M_BRD  = 3'd4
  } mode_e;
endpackage

// File: rtl/rcib_regfile.sv
module rcib_regfile #(
  parameter int NREG = 42
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic                  wide,
  input  logic [rcib_pkg::AW-1:0] addr,
  input  logic [15:0]           wdata,
  output logic [7:0]            rdata0,
  output logic [7:0]            rdata1
);
  import rcib_pkg::*;

  logic [7:0]    mem_q [NREG];
  logic [AW-1:0] addr_p1;

  assign addr_p1 = addr + 6'd1;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_cell
    logic       hit_first;
    logic       hit_second;
    logic [7:0] cell_d;

    assign hit_first  = we && (addr == AW'(gi));
    assign hit_second = we && wide && (addr_p1 == AW'(gi));

    always_comb begin
      cell_d = mem_q[gi];
      if (hit_first)       cell_d = wide ? wdata[15:8] : wdata[7:0];
      else if (hit_second) cell_d = wdata[7:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mem_q[gi] <= 8'h00;
      else if (hit_first || hit_second) mem_q[gi] <= cell_d;
    end
  end

  always_comb begin
    rdata0 = 8'h00;
    rdata1 = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (addr == AW'(i))    rdata0 = mem_q[i];
      if (addr_p1 == AW'(i)) rdata1 = mem_q[i];
    end
  end
endmodule

// File: rtl/rcib_outbuf.sv
module rcib_outbuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       load,
  input  logic       load_two,
  input  logic [7:0] ld0,
  input  logic [7:0] ld1,
  input  logic       consume,
  input  logic       consume_two,
  output logic [7:0] q0,
  output logic [7:0] q1,
  output logic [1:0] cnt
);
  logic [7:0] q0_q, q1_q, q0_d, q1_d;
  logic [1:0] cnt_q, cnt_d;

  always_comb begin
    q0_d  = q0_q;
    q1_d  = q1_q;
    cnt_d = cnt_q;
    if (load) begin
      q0_d  = ld0;
      q1_d  = load_two ? ld1 : 8'h00;
      cnt_d = load_two ? 2'd2 : 2'd1;
    end else if (clear) begin
      q0_d  = 8'h00;
      q1_d  = 8'h00;
      cnt_d = 2'd0;
    end else if (consume) begin
      if (consume_two) begin
        q0_d  = 8'h00;
        q1_d  = 8'h00;
        cnt_d = 2'd0;
      end else begin
        q0_d  = q1_q;
        q1_d  = 8'h00;
        cnt_d = cnt_q - 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q0_q  <= 8'h00;
      q1_q  <= 8'h00;
      cnt_q <= 2'd0;
    end else begin
      q0_q  <= q0_d;
      q1_q  <= q1_d;
      cnt_q <= cnt_d;
    end
  end

  assign q0  = q0_q;
  assign q1  = q1_q;
  assign cnt = cnt_q;

  // R6: the buffer never claims more than two queued bytes
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 2'd2);

  // R9: a lone single-byte take shrinks the count by one
  p_take_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !consume_two && !load && !clear) |=> (cnt_q == $past(cnt_q) - 2'd1));
endmodule

// File: rtl/rcib_ctrl.sv
module rcib_ctrl #(
  parameter int NSTROBE  = 14,
  parameter int FILLW    = 7,
  parameter int BUSY_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_instr_we,
  input  logic                    host_din_we,
  input  logic                    host_wide,
  input  logic [15:0]             host_wdata,
  input  logic                    host_instr_ar,
  input  logic                    host_rd,
  input  logic                    host_rd_wide,
  input  logic [1:0]              host_rd_ar,
  input  logic                    radio_nrdy,
  input  logic [2:0]              radio_state,
  input  logic [FILLW-1:0]        tx_fill,
  input  logic [FILLW-1:0]        rx_fill,
  input  logic [1:0]              buf_cnt,
  output logic [rcib_pkg::AW-1:0] acc_addr,
  output logic                    rf_we,
  output logic                    rf_wide,
  output logic                    buf_clear,
  output logic                    buf_load,
  output logic                    buf_load_two,
  output logic                    buf_consume,
  output logic                    buf_consume_two,
  output logic [7:0]              status,
  output logic [NSTROBE-1:0]      strobe,
  output logic                    err_operand,
  output logic                    err_nodata,
  output logic                    err_overwrite
);
  import rcib_pkg::*;

  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam logic [6:0] STB_END = 7'(48 + NSTROBE);

  mode_e             mode_q, mode_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [BW-1:0]     busy_q, busy_d;
  logic [7:0]        status_q, status_d;
  logic [NSTROBE-1:0] strobe_q, strobe_d;
  logic              eop_q, eop_d, end_q, end_d, eov_q, eov_d;

  logic [7:0]    ib;
  logic          busy;
  logic          is_strobe;
  logic [AW-1:0] stb_idx;
  logic [1:0]    need;

  function automatic logic [3:0] sat_fill(input logic [FILLW-1:0] f);
    return (f > FILLW'(15)) ? 4'hF : f[3:0];
  endfunction

  assign ib        = host_wide ? host_wdata[15:8] : host_wdata[7:0];
  assign busy      = (busy_q != '0);
  assign is_strobe = !ib[6] && ({1'b0, ib[5:0]} >= 7'h30) && ({1'b0, ib[5:0]} < STB_END);
  assign stb_idx   = ib[5:0] - STB_BASE;
  assign need      = host_rd_wide ? 2'd2 : 2'd1;

  always_comb begin
    mode_d          = mode_q;
    addr_d          = addr_q;
    busy_d          = busy ? busy_q - BW'(1) : busy_q;
    status_d        = status_q;
    strobe_d        = '0;
    eop_d           = 1'b0;
    end_d           = 1'b0;
    eov_d           = 1'b0;
    acc_addr        = addr_q;
    rf_we           = 1'b0;
    rf_wide         = 1'b0;
    buf_clear       = 1'b0;
    buf_load        = 1'b0;
    buf_load_two    = 1'b0;
    buf_consume     = 1'b0;
    buf_consume_two = 1'b0;

    if (host_instr_we) begin
      if (busy) begin
        eov_d = 1'b1;
      end else begin
        if (mode_q == M_SWR || mode_q == M_SRD) eop_d = 1'b1;
        status_d  = {radio_nrdy, radio_state, ib[7] ? sat_fill(rx_fill) : sat_fill(tx_fill)};
        buf_clear = 1'b1;
        acc_addr  = ib[5:0];
        addr_d    = ib[5:0];
        mode_d    = M_IDLE;
        if (is_strobe) begin
          strobe_d = NSTROBE'(1) << stb_idx;
          if (host_wide) eop_d = 1'b1;
        end else if (host_wide || (host_instr_ar && ib[7])) begin
          if (host_wide) busy_d = BW'(BUSY_CYC);
          addr_d = ib[6] ? ib[5:0] + 6'd1 : ib[5:0];
          if (ib[7]) begin
            buf_load = 1'b1;
            mode_d   = ib[6] ? M_BRD : M_IDLE;
          end else begin
            rf_we  = 1'b1;
            mode_d = ib[6] ? M_BWR : M_IDLE;
          end
        end else begin
          case ({ib[7], ib[6]})
            2'b00:   mode_d = M_SWR;
            2'b01:   mode_d = M_BWR;
            2'b10:   mode_d = M_SRD;
            default: mode_d = M_BRD;
          endcase
        end
      end
    end else if (host_din_we) begin
      if (busy) begin
        eov_d = 1'b1;
      end else begin
        case (mode_q)
          M_SWR, M_SRD: begin
            if (host_wide) begin
              eop_d = 1'b1;
            end else begin
              rf_we    = (mode_q == M_SWR);
              buf_load = (mode_q == M_SRD);
              mode_d   = M_IDLE;
              busy_d   = BW'(BUSY_CYC);
            end
          end
          M_BWR, M_BRD: begin
            rf_we        = (mode_q == M_BWR);
            rf_wide      = (mode_q == M_BWR) && host_wide;
            buf_load     = (mode_q == M_BRD);
            buf_load_two = (mode_q == M_BRD) && host_wide;
            addr_d       = addr_q + (host_wide ? 6'd2 : 6'd1);
            busy_d       = BW'(BUSY_CYC);
          end
          default: eop_d = 1'b1;
        endcase
      end
    end else if (host_rd) begin
      if (buf_cnt < need) begin
        end_d = 1'b1;
      end else begin
        buf_consume     = 1'b1;
        buf_consume_two = host_rd_wide;
        if (host_rd_ar != 2'd0) begin
          if (mode_q == M_BRD) begin
            buf_load     = 1'b1;
            buf_load_two = host_rd_ar[1];
            addr_d       = addr_q + (host_rd_ar[1] ? 6'd2 : 6'd1);
          end else begin
            eop_d = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_IDLE;
      addr_q   <= '0;
      busy_q   <= '0;
      status_q <= 8'h00;
      strobe_q <= '0;
      eop_q    <= 1'b0;
      end_q    <= 1'b0;
      eov_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      addr_q   <= addr_d;
      busy_q   <= busy_d;
      status_q <= status_d;
      strobe_q <= strobe_d;
      eop_q    <= eop_d;
      end_q    <= end_d;
      eov_q    <= eov_d;
    end
  end

  assign status        = status_q;
  assign strobe        = strobe_q;
  assign err_operand   = eop_q;
  assign err_nodata    = end_q;
  assign err_overwrite = eov_q;

  // R5: at most one strobe line at a time, and only after an instruction write
  p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_q));
  p_strobe_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q != '0) |-> $past(host_instr_we));

  // R1: status moves only when an instruction is written
  p_status_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !host_instr_we |=> $stable(status_q));

  // R10: a data-in write inside the busy window is flagged
  p_overwrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_din_we && !host_instr_we && busy) |=> err_overwrite);

  // R9: a host read larger than the queued data is flagged
  p_nodata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_instr_we && !host_din_we && (buf_cnt < need)) |=> err_nodata);
endmodule

// File: rtl/rcib_bridge.sv
module rcib_bridge #(
  parameter int NREG     = 42,
  parameter int NSTROBE  = 14,
  parameter int FILLW    = 7,
  parameter int BUSY_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_instr_we,
  input  logic               host_din_we,
  input  logic               host_wide,
  input  logic [15:0]        host_wdata,
  input  logic               host_instr_ar,
  input  logic               host_rd,
  input  logic               host_rd_wide,
  input  logic [1:0]         host_rd_ar,
  input  logic               radio_nrdy,
  input  logic [2:0]         radio_state,
  input  logic [FILLW-1:0]   tx_fill,
  input  logic [FILLW-1:0]   rx_fill,
  output logic [7:0]         status,
  output logic [7:0]         dout_byte,
  output logic [15:0]        dout_word,
  output logic [NSTROBE-1:0] strobe,
  output logic               err_operand,
  output logic               err_nodata,
  output logic               err_overwrite
);
  import rcib_pkg::*;

  logic [AW-1:0] acc_addr;
  logic          rf_we, rf_wide;
  logic [7:0]    rdata0, rdata1;
  logic          buf_clear, buf_load, buf_load_two, buf_consume, buf_consume_two;
  logic [7:0]    q0, q1;
  logic [1:0]    buf_cnt;

  rcib_ctrl #(
    .NSTROBE (NSTROBE),
    .FILLW   (FILLW),
    .BUSY_CYC(BUSY_CYC)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_instr_we   (host_instr_we),
    .host_din_we     (host_din_we),
    .host_wide       (host_wide),
    .host_wdata      (host_wdata),
    .host_instr_ar   (host_instr_ar),
    .host_rd         (host_rd),
    .host_rd_wide    (host_rd_wide),
    .host_rd_ar      (host_rd_ar),
    .radio_nrdy      (radio_nrdy),
    .radio_state     (radio_state),
    .tx_fill         (tx_fill),
    .rx_fill         (rx_fill),
    .buf_cnt         (buf_cnt),
    .acc_addr        (acc_addr),
    .rf_we           (rf_we),
    .rf_wide         (rf_wide),
    .buf_clear       (buf_clear),
    .buf_load        (buf_load),
    .buf_load_two    (buf_load_two),
    .buf_consume     (buf_consume),
    .buf_consume_two (buf_consume_two),
    .status          (status),
    .strobe          (strobe),
    .err_operand     (err_operand),
    .err_nodata      (err_nodata),
    .err_overwrite   (err_overwrite)
  );

  rcib_regfile #(.NREG(NREG)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (rf_we),
    .wide   (rf_wide),
    .addr   (acc_addr),
    .wdata  (host_wdata),
    .rdata0 (rdata0),
    .rdata1 (rdata1)
  );

  rcib_outbuf u_obuf (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (buf_clear),
    .load        (buf_load),
    .load_two    (buf_load_two),
    .ld0         (rdata0),
    .ld1         (rdata1),
    .consume     (buf_consume),
    .consume_two (buf_consume_two),
    .q0          (q0),
    .q1          (q1),
    .cnt         (buf_cnt)
  );

  assign dout_byte = q0;
  assign dout_word = {q0, q1};
endmodule

// File: tb/rcib_bridge_test.sv
module rcib_bridge_test;
  localparam int NREG = 42;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_instr_we = 1'b0, host_din_we = 1'b0, host_wide = 1'b0;
  logic [15:0] host_wdata = 16'h0;
  logic        host_instr_ar = 1'b0, host_rd = 1'b0, host_rd_wide = 1'b0;
  logic [1:0]  host_rd_ar = 2'd0;
  logic        radio_nrdy = 1'b0;
  logic [2:0]  radio_state = 3'd0;
  logic [6:0]  tx_fill = 7'd0, rx_fill = 7'd0;
  logic [7:0]  status, dout_byte;
  logic [15:0] dout_word;
  logic [13:0] strobe;
  logic        err_operand, err_nodata, err_overwrite;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic f_op, f_nd, f_ov;
  logic [13:0] f_stb;
  logic [7:0] mdl [64];

  always #10 clk = ~clk;

  rcib_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .host_instr_we(host_instr_we), .host_din_we(host_din_we), .host_wide(host_wide),
    .host_wdata(host_wdata), .host_instr_ar(host_instr_ar),
    .host_rd(host_rd), .host_rd_wide(host_rd_wide), .host_rd_ar(host_rd_ar),
    .radio_nrdy(radio_nrdy), .radio_state(radio_state), .tx_fill(tx_fill), .rx_fill(rx_fill),
    .status(status), .dout_byte(dout_byte), .dout_word(dout_word), .strobe(strobe),
    .err_operand(err_operand), .err_nodata(err_nodata), .err_overwrite(err_overwrite)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic [7:0] ib);
    logic [6:0] f;
    f = ib[7] ? rx_fill : tx_fill;
    return {radio_nrdy, radio_state, (f > 7'd15) ? 4'hF : f[3:0]};
  endfunction

  function automatic logic [7:0] exp_reg(input logic [5:0] a);
    return (a < 6'(NREG)) ? mdl[a] : 8'h00;
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic capture();
    f_op = err_operand; f_nd = err_nodata; f_ov = err_overwrite; f_stb = strobe;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic put_instr(input logic [7:0] ib, input logic ar);
    host_instr_we = 1'b1; host_wide = 1'b0; host_wdata = {8'h00, ib}; host_instr_ar = ar;
    cyc();
    capture();
    host_instr_we = 1'b0; host_instr_ar = 1'b0;
  endtask

  task automatic put_instr_w(input logic [7:0] ib, input logic [7:0] lo);
    host_instr_we = 1'b1; host_wide = 1'b1; host_wdata = {ib, lo};
    cyc();
    capture();
    host_instr_we = 1'b0; host_wide = 1'b0;
    idle(2);
  endtask

  task automatic put_din(input logic [15:0] d, input logic wide, input int gap);
    host_din_we = 1'b1; host_wide = wide; host_wdata = d;
    cyc();
    capture();
    host_din_we = 1'b0; host_wide = 1'b0;
    idle(gap);
  endtask

  task automatic get(input logic wide, input logic [1:0] ar, output logic [15:0] val);
    val = wide ? dout_word : {8'h00, dout_byte};
    host_rd = 1'b1; host_rd_wide = wide; host_rd_ar = ar;
    cyc();
    capture();
    host_rd = 1'b0; host_rd_wide = 1'b0; host_rd_ar = 2'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk("R11 status", status, 8'h00);
    chk("R11 dout", dout_word, 16'h0000);
    chk("R11 pulses", {strobe, err_operand, err_nodata, err_overwrite}, 17'h0);

    // R2/R3/R1: single write then single read
    radio_state = 3'd3; rx_fill = 7'd20; tx_fill = 7'd9;
    put_instr(8'h05, 1'b0);
    chk("R1 status write", status, exp_status(8'h05));
    put_din(16'h00A5, 1'b0, 2); mdl[5] = 8'hA5;
    chk("R2 no error", {f_op, f_ov}, 2'b00);
    put_instr(8'h85, 1'b0);
    chk("R1 status rx saturated", status, 8'h3F);
    put_din(16'h0000, 1'b0, 2);
    chk("R3 single read", dout_byte, 8'hA5);

    // R6/R8: auto-read refused on a single read
    put_instr(8'h85, 1'b1);
    chk("R6 instr autoread", dout_byte, 8'hA5);
    get(1'b0, 2'd1, v);
    chk("R8 autoread outside burst", f_op, 1'b1);

    // R7/R4/R6: word instruction, word data-in, auto-read chain
    put_instr_w(8'h51, 8'h11); mdl[6'h11] = 8'h11;
    put_din(16'h2233, 1'b1, 2); mdl[6'h12] = 8'h22; mdl[6'h13] = 8'h33;
    put_instr(8'hD1, 1'b1);
    chk("R6 first fetch", dout_byte, 8'h11);
    get(1'b0, 2'd2, v);
    chk("R7 word order", dout_word, 16'h2233);
    get(1'b1, 2'd0, v);
    chk("R9 word take ok", f_nd, 1'b0);
    get(1'b0, 2'd0, v);
    chk("R9 empty read", f_nd, 1'b1);

    // R5: strobes with both count selections
    tx_fill = 7'd5; rx_fill = 7'd12; radio_state = 3'd1;
    put_instr(8'h36, 1'b0);
    chk("R5 strobe line", f_stb, 14'h0040);
    chk("R5 strobe status tx", status, 8'h15);
    idle(1);
    chk("R5 strobe one cycle", strobe, 14'h0);
    put_instr(8'hB0, 1'b0);
    chk("R5 strobe line 0", f_stb, 14'h0001);
    chk("R5 strobe status rx", status, 8'h1C);

    // R8: operand with no open instruction
    put_din(16'h0012, 1'b0, 2);
    chk("R8 no instruction", f_op, 1'b1);

    // R10/R4: overwrite inside busy window
    put_instr(8'h60, 1'b0);
    put_din(16'h0077, 1'b0, 0); mdl[6'h20] = 8'h77;
    put_din(16'h0088, 1'b0, 2);
    chk("R10 overwrite flagged", f_ov, 1'b1);
    put_din(16'h0099, 1'b0, 2); mdl[6'h21] = 8'h99;
    chk("R10 after window", f_ov, 1'b0);
    put_instr(8'hE0, 1'b1);
    get(1'b0, 2'd1, v);
    chk("R4 burst first", v, 16'h0077);
    chk("R10 ignored byte", dout_byte, 8'h99);
    get(1'b0, 2'd0, v);

    // R8: word operand to single write, then too few operands
    put_instr(8'h07, 1'b0);
    put_din(16'h1234, 1'b1, 2);
    chk("R8 word to single", f_op, 1'b1);
    put_instr(8'h87, 1'b0);
    chk("R8 too few", f_op, 1'b1);
    put_din(16'h0000, 1'b0, 2);
    chk("R8 operand discarded", dout_byte, 8'h00);

    // R12: unmapped address
    put_instr(8'h2C, 1'b0);
    put_din(16'h005A, 1'b0, 2);
    put_instr(8'hAC, 1'b1);
    chk("R12 unmapped reads zero", dout_byte, 8'h00);

    // Random bursts against a register image (R4, R2, R1, R6)
    for (int it = 0; it < 30; it++) begin
      int start, len;
      start = $urandom_range(0, NREG - 5);
      len = $urandom_range(1, 4);
      tx_fill = 7'($urandom_range(0, 64)); rx_fill = 7'($urandom_range(0, 64));
      radio_state = 3'($urandom); radio_nrdy = 1'($urandom);
      put_instr(8'h40 | 8'(start), 1'b0);
      chk("R1 random status", status, exp_status(8'h40 | 8'(start)));
      for (int j = 0; j < len; j++) begin
        logic [7:0] d;
        d = 8'($urandom);
        put_din({8'h00, d}, 1'b0, 2);
        mdl[start + j] = d;
      end
      put_instr(8'hC0 | 8'(start), 1'b1);
      for (int j = 0; j < len; j++) begin
        get(1'b0, (j < len - 1) ? 2'd1 : 2'd0, v);
        chk("R4 random burst", v, {8'h00, exp_reg(6'(start + j))});
      end
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule